// File: doc/BRIEF.md
# NAND command and pointer sequencer

This block is the command front end on the device side of a small-page NAND memory. A host writes bytes on an 8-bit bus. Each write is qualified by a command-latch flag or an address-latch flag and arrives as a one-cycle write strobe. The block reads each byte as a command, an address byte or a program data byte. It walks the multi-cycle sequences for page read, page program, block erase, identification, status and reset. When a sequence completes, it emits a one-cycle operation pulse carrying the operation kind, the start column inside the 528-byte page and the row address.

The upper column bits never travel as an address. Three pointer commands choose which region of the page the single column byte is an offset into: the low half, the high half or the 16-byte spare region. The block remembers the last latched read pointer, so a bare address sequence starts another read. It also keeps a tally of partial programs for the page it last programmed, and it refuses programs beyond the allowed count. Busy periods are counted cycles set by parameters; the array itself lies outside this block.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, busy, opValid and ioOut are all zero, and the read pointer is the low half, so an address-only read gives startCol equal to the column byte.
- R2: A read needs one column byte and then three row bytes, least significant first. The cycle after the last address write, opValid pulses with opKind=1, and startCol is set by the pointer: 00h gives the offset, 01h gives 256 plus the offset, and 50h gives 512 plus the low 4 bits of the offset. rowAddr holds the three row bytes, first byte in bits 7:0.
- R3: Pointers 00h and 50h stay in force across later reads. Pointer 01h applies to one read or program only, and the pointer then returns to the low half. A column-plus-row address sequence with no command in front starts a read.
- R4: busy rises in the cycle after the write that starts an operation and stays high for 8 cycles (read), 20 cycles (program), 30 cycles (erase) or 5 cycles (reset).
- R5: 80h, one column byte, three row bytes, any number of data bytes and then 10h start a program: opValid with opKind=2, the startCol and the rowAddr.
- R6: 60h, three row bytes and then D0h start an erase with opKind=3. A D0h that does not follow a complete erase address starts nothing.
- R7: For one page, at most 2 programs with startCol below 512 and at most 3 with startCol of 512 or above are accepted. A further program produces no opValid and no busy, and it sets the fail bit. An erase of the block holding that page (row bits 23:5 equal) clears the tally.
- R8: After 90h and one address byte, successive read strobes return ECh and then 76h, and 76h again on any later strobe.
- R9: After 70h, a read strobe returns a status byte: bit 6 is the inverse of busy and bit 0 is the fail flag. The fail flag is cleared by the next accepted program.
- R10: FFh is accepted at any time, even while busy. It abandons any sequence, returns the pointer to the low half and starts the reset busy period.
- R11: While busy, every write other than FFh and 70h is ignored.
- R12: A command arriving in the middle of a sequence abandons that sequence, and the command is then decoded as a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cle | input | 1 | Marks the written byte as a command |
| ale | input | 1 | Marks the written byte as an address byte |
| wrEn | input | 1 | One-cycle write strobe (bus write edge) |
| rdEn | input | 1 | One-cycle read strobe for ID or status bytes |
| ioIn | input | 8 | Written byte |
| opValid | output | 1 | One-cycle pulse when an operation starts |
| opKind | output | 2 | 1 read, 2 program, 3 erase (last started) |
| startCol | output | 10 | Start column within the page |
| rowAddr | output | 24 | Row (page) address |
| busy | output | 1 | High while an operation or reset runs |
| ioOut | output | 8 | ID or status byte, updated on rdEn |

## Verification
The hardest situation to reach is the refused partial program. Getting there takes several complete program sequences to one page in the same area, each one separated by a full busy period. It then takes an erase of the matching block and a further program that must be accepted again. The bench builds this with a program-sequence task aimed at one row, first in the main area and then in the spare area after a 50h pointer. It reads the outcome through the status byte. Writes made while busy are checked the same way, by showing that a later address-only read still uses the old pointer.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int ROW_BYTES   = 3;
  localparam int ROW_W       = 8 * ROW_BYTES;
  localparam int ROW_IDX_W   = $clog2(ROW_BYTES + 1);
  localparam int AREA_BYTES  = 256;
  localparam int SPARE_BYTES = 16;
  localparam int SPARE_BASE  = 2 * AREA_BYTES;
  localparam int COL_W       = $clog2(SPARE_BASE + SPARE_BYTES);
  localparam int SPARE_OFS_W = $clog2(SPARE_BYTES);

  localparam logic [7:0] CMD_PTR_A   = 8'h00;
  localparam logic [7:0] CMD_PTR_B   = 8'h01;
  localparam logic [7:0] CMD_PTR_C   = 8'h50;
  localparam logic [7:0] CMD_PG_SET  = 8'h80;
  localparam logic [7:0] CMD_PG_GO   = 8'h10;
  localparam logic [7:0] CMD_ER_SET  = 8'h60;
  localparam logic [7:0] CMD_ER_GO   = 8'hD0;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} opKind_e;
  typedef enum logic [1:0] {AREA_A, AREA_B, AREA_C} area_e;
  typedef enum logic [1:0] {RD_NONE, RD_ID, RD_STATUS} rdMode_e;

  typedef struct packed {
    logic                 setPtr;
    area_e                ptrSel;
    logic                 latchCol;
    logic                 latchRow;
    logic [ROW_IDX_W-1:0] rowIdx;
    logic                 startRead;
    logic                 confirmProg;
    logic                 startErase;
    logic                 doReset;
    logic                 modeId;
    logic                 modeStatus;
  } seqStrobe_t;
endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cle,
  input  logic       ale,
  input  logic       wrEn,
  input  logic [7:0] ioIn,
  input  logic       busy,
  output seqStrobe_t strb
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADDR, S_PG_ADDR, S_PG_DATA, S_ER_ADDR, S_ER_CONF, S_ID_ADDR, S_ID_OUT
  } seqState_e;

  seqState_e state, nState;
  logic [ROW_IDX_W-1:0] addrIdx, nIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      addrIdx <= '0;
    end else begin
      state   <= nState;
      addrIdx <= nIdx;
    end
  end

  always_comb begin
    strb   = '0;
    nState = state;
    nIdx   = addrIdx;
    if (wrEn && cle) begin
      if (ioIn == CMD_RESET) begin
        strb.doReset = 1'b1;
        nState = S_IDLE;
        nIdx   = '0;
      end else if (ioIn == CMD_STATUS) begin
        strb.modeStatus = 1'b1;
        nState = S_IDLE;
        nIdx   = '0;
      end else if (!busy) begin
        nState = S_IDLE;
        nIdx   = '0;
        case (ioIn)
          CMD_PTR_A: begin strb.setPtr = 1'b1; strb.ptrSel = AREA_A; nState = S_RD_ADDR; end
          CMD_PTR_B: begin strb.setPtr = 1'b1; strb.ptrSel = AREA_B; nState = S_RD_ADDR; end
          CMD_PTR_C: begin strb.setPtr = 1'b1; strb.ptrSel = AREA_C; nState = S_RD_ADDR; end
          CMD_PG_SET: nState = S_PG_ADDR;
          CMD_PG_GO:  strb.confirmProg = (state == S_PG_DATA);
          CMD_ER_SET: nState = S_ER_ADDR;
          CMD_ER_GO:  strb.startErase = (state == S_ER_CONF);
          CMD_IDENT:  nState = S_ID_ADDR;
          default: ;
        endcase
      end
    end else if (wrEn && ale && !busy) begin
      case (state)
        S_IDLE, S_RD_ADDR, S_PG_ADDR: begin
          if (addrIdx == '0) begin
            strb.latchCol = 1'b1;
          end else begin
            strb.latchRow = 1'b1;
            strb.rowIdx   = addrIdx - ROW_IDX_W'(1);
          end
          if (addrIdx == ROW_IDX_W'(ROW_BYTES)) begin
            nIdx = '0;
            if (state == S_PG_ADDR) begin
              nState = S_PG_DATA;
            end else begin
              strb.startRead = 1'b1;
              nState = S_IDLE;
            end
          end else begin
            nIdx = addrIdx + ROW_IDX_W'(1);
            if (state == S_IDLE) nState = S_RD_ADDR;
          end
        end
        S_ER_ADDR: begin
          strb.latchRow = 1'b1;
          strb.rowIdx   = addrIdx;
          if (addrIdx == ROW_IDX_W'(ROW_BYTES - 1)) begin
            nIdx   = '0;
            nState = S_ER_CONF;
          end else begin
            nIdx = addrIdx + ROW_IDX_W'(1);
          end
        end
        S_ID_ADDR: begin
          strb.modeId = 1'b1;
          nState = S_ID_OUT;
        end
        default: ;
      endcase
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && !cle) |=> ($stable(state) && $stable(addrIdx))); // R11
endmodule

// File: rtl/nand_seq_dpath.sv
module nand_seq_dpath
  import nand_seq_pkg::*;
#(
  parameter int BUSY_READ     = 8,
  parameter int BUSY_PROG     = 20,
  parameter int BUSY_ERASE    = 30,
  parameter int BUSY_RESET    = 5,
  parameter int MAIN_PP_MAX   = 2,
  parameter int SPARE_PP_MAX  = 3,
  parameter int BLOCK_SHIFT   = 5,
  parameter logic [7:0] MAKER_ID  = 8'hEC,
  parameter logic [7:0] DEVICE_ID = 8'h76
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic [7:0]       ioIn,
  input  seqStrobe_t       strb,
  output logic             opValid,
  output opKind_e          opKind,
  output logic [COL_W-1:0] startCol,
  output logic [ROW_W-1:0] rowAddr,
  output logic             busy,
  output logic [7:0]       ioOut
);
  localparam int MAX_A    = (BUSY_READ > BUSY_PROG) ? BUSY_READ : BUSY_PROG;
  localparam int MAX_B    = (BUSY_ERASE > BUSY_RESET) ? BUSY_ERASE : BUSY_RESET;
  localparam int MAX_BUSY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W    = $clog2(MAX_BUSY + 1);
  localparam int PP_MAX   = (MAIN_PP_MAX > SPARE_PP_MAX) ? MAIN_PP_MAX : SPARE_PP_MAX;
  localparam int PP_W     = $clog2(PP_MAX + 1);

  area_e            ptrArea;
  rdMode_e          rdMode;
  logic             idIdx;
  logic [TMR_W-1:0] busyCnt;
  logic [ROW_W-1:0] trackRow;
  logic             trackValid;
  logic [PP_W-1:0]  mainCnt, spareCnt, curMain, curSpare;
  logic             failFlag, sameRow, sameBlock, isSpare, progOk, progGo;

  assign busy      = (busyCnt != '0);
  assign sameRow   = trackValid && (trackRow == rowAddr);
  assign sameBlock = trackValid && (trackRow[ROW_W-1:BLOCK_SHIFT] == rowAddr[ROW_W-1:BLOCK_SHIFT]);
  assign curMain   = sameRow ? mainCnt : '0;
  assign curSpare  = sameRow ? spareCnt : '0;
  assign isSpare   = (startCol >= COL_W'(SPARE_BASE));
  assign progOk    = isSpare ? (curSpare < PP_W'(SPARE_PP_MAX)) : (curMain < PP_W'(MAIN_PP_MAX));
  assign progGo    = strb.confirmProg && progOk;

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
    logic [7:0] byteQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) byteQ <= '0;
      else if (strb.latchRow && strb.rowIdx == ROW_IDX_W'(g)) byteQ <= ioIn;
    end
    assign rowAddr[8*g +: 8] = byteQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCol <= '0;
      ptrArea  <= AREA_A;
    end else begin
      if (strb.latchCol) begin
        case (ptrArea)
          AREA_B:  startCol <= COL_W'(AREA_BYTES) + COL_W'(ioIn);
          AREA_C:  startCol <= COL_W'(SPARE_BASE) + COL_W'(ioIn[SPARE_OFS_W-1:0]);
          default: startCol <= COL_W'(ioIn);
        endcase
      end
      if (strb.doReset) ptrArea <= AREA_A;
      else if (strb.setPtr) ptrArea <= strb.ptrSel;
      else if ((strb.startRead || strb.confirmProg) && ptrArea == AREA_B) ptrArea <= AREA_A;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      opValid <= 1'b0;
      opKind  <= OP_NONE;
    end else begin
      opValid <= strb.startRead || progGo || strb.startErase;
      if (strb.doReset) busyCnt <= TMR_W'(BUSY_RESET);
      else if (strb.startRead) begin busyCnt <= TMR_W'(BUSY_READ); opKind <= OP_READ; end
      else if (progGo) begin busyCnt <= TMR_W'(BUSY_PROG); opKind <= OP_PROG; end
      else if (strb.startErase) begin busyCnt <= TMR_W'(BUSY_ERASE); opKind <= OP_ERASE; end
      else if (busy) busyCnt <= busyCnt - TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trackRow   <= '0;
      trackValid <= 1'b0;
      mainCnt    <= '0;
      spareCnt   <= '0;
      failFlag   <= 1'b0;
    end else if (strb.doReset) begin
      failFlag <= 1'b0;
    end else if (strb.confirmProg) begin
      failFlag <= !progOk;
      if (progOk) begin
        trackRow   <= rowAddr;
        trackValid <= 1'b1;
        mainCnt    <= curMain + PP_W'(!isSpare);
        spareCnt   <= curSpare + PP_W'(isSpare);
      end
    end else if (strb.startErase && sameBlock) begin
      trackValid <= 1'b0;
      mainCnt    <= '0;
      spareCnt   <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdMode <= RD_NONE;
      idIdx  <= 1'b0;
      ioOut  <= '0;
    end else begin
      if (strb.doReset || strb.setPtr || strb.startRead) rdMode <= RD_NONE;
      else if (strb.modeId) begin rdMode <= RD_ID; idIdx <= 1'b0; end
      else if (strb.modeStatus) rdMode <= RD_STATUS;
      if (rdEn) begin
        case (rdMode)
          RD_ID: begin ioOut <= idIdx ? DEVICE_ID : MAKER_ID; idIdx <= 1'b1; end
          RD_STATUS: ioOut <= {1'b0, !busy, 5'b0, failFlag};
          default: ioOut <= '0;
        endcase
      end
    end
  end

  AST_OP_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> busy); // R4
  AST_PP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (mainCnt <= PP_W'(MAIN_PP_MAX)) && (spareCnt <= PP_W'(SPARE_PP_MAX))); // R7
  AST_PTR_REVERT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.startRead) && $past(ptrArea) == AREA_B) |-> (ptrArea == AREA_A)); // R3
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.doReset) |-> (busy && ptrArea == AREA_A)); // R10
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int BUSY_READ    = 8,
  parameter int BUSY_PROG    = 20,
  parameter int BUSY_ERASE   = 30,
  parameter int BUSY_RESET   = 5,
  parameter int MAIN_PP_MAX  = 2,
  parameter int SPARE_PP_MAX = 3,
  parameter int BLOCK_SHIFT  = 5,
  parameter logic [7:0] MAKER_ID  = 8'hEC,
  parameter logic [7:0] DEVICE_ID = 8'h76
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cle,
  input  logic             ale,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [7:0]       ioIn,
  output logic             opValid,
  output logic [1:0]       opKind,
  output logic [COL_W-1:0] startCol,
  output logic [ROW_W-1:0] rowAddr,
  output logic             busy,
  output logic [7:0]       ioOut
);
  seqStrobe_t strb;
  opKind_e    kindE;

  nand_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cle(cle), .ale(ale), .wrEn(wrEn),
    .ioIn(ioIn), .busy(busy), .strb(strb)
  );

  nand_seq_dpath #(
    .BUSY_READ(BUSY_READ), .BUSY_PROG(BUSY_PROG), .BUSY_ERASE(BUSY_ERASE),
    .BUSY_RESET(BUSY_RESET), .MAIN_PP_MAX(MAIN_PP_MAX), .SPARE_PP_MAX(SPARE_PP_MAX),
    .BLOCK_SHIFT(BLOCK_SHIFT), .MAKER_ID(MAKER_ID), .DEVICE_ID(DEVICE_ID)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .ioIn(ioIn), .strb(strb),
    .opValid(opValid), .opKind(kindE), .startCol(startCol), .rowAddr(rowAddr),
    .busy(busy), .ioOut(ioOut)
  );

  assign opKind = kindE;
endmodule

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cle = 1'b0, ale = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] ioIn = '0;
  logic opValid, busy;
  logic [1:0] opKind;
  logic [9:0] startCol;
  logic [23:0] rowAddr;
  logic [7:0] ioOut;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_seq i_nand_cmd_seq (
    .clk(clk), .rstN(rstN), .cle(cle), .ale(ale), .wrEn(wrEn), .rdEn(rdEn),
    .ioIn(ioIn), .opValid(opValid), .opKind(opKind), .startCol(startCol),
    .rowAddr(rowAddr), .busy(busy), .ioOut(ioOut)
  );

  // {type(0 cmd,1 addr), byte, expected kind (0 none), expected startCol}
  // R1: first read has no command (default low half); R3: persistence and one-shot 01h
  localparam logic [21:0] VEC [NVEC] = '{
    {2'd1,8'h10,2'd0,10'h000},{2'd1,8'h01,2'd0,10'h000},{2'd1,8'h00,2'd0,10'h000},{2'd1,8'h00,2'd1,10'h010},
    {2'd0,8'h01,2'd0,10'h000},{2'd1,8'h20,2'd0,10'h000},{2'd1,8'h02,2'd0,10'h000},{2'd1,8'h00,2'd0,10'h000},{2'd1,8'h00,2'd1,10'h120},
    {2'd1,8'h05,2'd0,10'h000},{2'd1,8'h03,2'd0,10'h000},{2'd1,8'h00,2'd0,10'h000},{2'd1,8'h00,2'd1,10'h005},
    {2'd0,8'h50,2'd0,10'h000},{2'd1,8'h07,2'd0,10'h000},{2'd1,8'h04,2'd0,10'h000},{2'd1,8'h00,2'd0,10'h000},{2'd1,8'h00,2'd1,10'h207},
    {2'd1,8'h1F,2'd0,10'h000},{2'd1,8'h05,2'd0,10'h000},{2'd1,8'h00,2'd0,10'h000},{2'd1,8'h00,2'd1,10'h20F},
    {2'd0,8'h00,2'd0,10'h000},{2'd1,8'hFF,2'd0,10'h000},{2'd1,8'h06,2'd0,10'h000},{2'd1,8'h00,2'd0,10'h000},{2'd1,8'h00,2'd1,10'h0FF},
    {2'd1,8'hAB,2'd0,10'h000},{2'd1,8'h07,2'd0,10'h000},{2'd1,8'h00,2'd0,10'h000},{2'd1,8'h00,2'd1,10'h0AB}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] v);
    @(negedge clk); cle = c; ale = a; ioIn = v; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic addr4(input logic [7:0] col, input logic [7:0] r0, input logic [7:0] r1, input logic [7:0] r2);
    wr(0, 1, col); wr(0, 1, r0); wr(0, 1, r1); wr(0, 1, r2);
  endtask

  task automatic progSeq(input logic [7:0] col, input logic [7:0] row, input logic expOk,
                         input logic [9:0] expCol, input string tag);
    wr(1, 0, 8'h80);
    addr4(col, row, 8'h00, 8'h00);
    wr(0, 0, 8'hA5); wr(0, 0, 8'h5A);
    wr(1, 0, 8'h10);
    if (expOk) chk(tag, {opValid, opKind, startCol}, {1'b1, 2'd2, expCol});
    else       chk(tag, {opValid, busy}, 2'b00);
    waitReady();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {opValid, busy, ioOut}, 10'h000);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][21:20] == 2'd0, VEC[i][21:20] == 2'd1, VEC[i][19:12]);
      if (VEC[i][11:10] == 2'd0) chk("R2 table no op", {31'd0, opValid}, 32'd0);
      else chk("R2 table read", {opValid, opKind, startCol}, {1'b1, VEC[i][11:10], VEC[i][9:0]});
      waitReady();
    end

    // R2 row byte order, R4 read busy length
    wr(1, 0, 8'h00); addr4(8'h00, 8'h01, 8'h02, 8'h03);
    chk("R2 rowAddr", rowAddr, 32'h030201);
    busyLen(n); chk("R4 read busy", n, 8);

    // R8 identification
    wr(1, 0, 8'h90); wr(0, 1, 8'h00);
    rd(); chk("R8 maker", ioOut, 8'hEC);
    rd(); chk("R8 device", ioOut, 8'h76);
    rd(); chk("R8 device again", ioOut, 8'h76);

    // R5 program, R4 program busy, R7 main-area limit, R9 status
    wr(1, 0, 8'h80); addr4(8'h00, 8'h40, 8'h00, 8'h00);
    wr(0, 0, 8'h11); wr(0, 0, 8'h22); wr(1, 0, 8'h10);
    chk("R5 program op", {opValid, opKind, startCol, rowAddr}, {1'b1, 2'd2, 10'h000, 24'h000040});
    busyLen(n); chk("R4 program busy", n, 20);
    progSeq(8'h00, 8'h40, 1'b1, 10'h000, "R7 second main program");
    progSeq(8'h00, 8'h40, 1'b0, 10'h000, "R7 third main refused");
    wr(1, 0, 8'h70); rd(); chk("R9 status fail", ioOut, 8'h41);

    // R7 spare-area limit
    wr(1, 0, 8'h50);
    progSeq(8'h02, 8'h40, 1'b1, 10'h202, "R7 spare 1");
    progSeq(8'h02, 8'h40, 1'b1, 10'h202, "R7 spare 2");
    progSeq(8'h02, 8'h40, 1'b1, 10'h202, "R7 spare 3");
    progSeq(8'h02, 8'h40, 1'b0, 10'h202, "R7 spare 4 refused");

    // R6 erase, R4 erase busy, R7 tally cleared, R9 fail cleared
    wr(1, 0, 8'h60); wr(0, 1, 8'h40); wr(0, 1, 8'h00); wr(0, 1, 8'h00); wr(1, 0, 8'hD0);
    chk("R6 erase op", {opValid, opKind}, {1'b1, 2'd3});
    busyLen(n); chk("R4 erase busy", n, 30);
    wr(1, 0, 8'h00);
    progSeq(8'h00, 8'h40, 1'b1, 10'h000, "R7 accepted after erase");
    wr(1, 0, 8'h70); rd(); chk("R9 status pass", ioOut, 8'h40);

    // R6 incomplete erase address
    wr(1, 0, 8'h60); wr(0, 1, 8'h40); wr(1, 0, 8'hD0);
    chk("R6 short erase", {opValid, busy}, 2'b00);
    wr(1, 0, 8'hD0);
    chk("R6 lone confirm", {opValid, busy}, 2'b00);

    // R11 writes while busy ignored, R9 status while busy
    wr(1, 0, 8'h00); addr4(8'h00, 8'h00, 8'h00, 8'h00);
    wr(1, 0, 8'h50); wr(0, 1, 8'h33);
    chk("R11 no op while busy", {31'd0, opValid}, 32'd0);
    wr(1, 0, 8'h70); rd(); chk("R9 status busy", ioOut, 8'h00);
    waitReady();
    addr4(8'h11, 8'h00, 8'h00, 8'h00);
    chk("R11 pointer unchanged", {opValid, startCol}, {1'b1, 10'h011});
    waitReady();

    // R10 reset: pointer back to low half, busy length, accepted while busy
    wr(1, 0, 8'h50); wr(1, 0, 8'hFF);
    busyLen(n); chk("R10 reset busy", n, 5);
    addr4(8'h22, 8'h00, 8'h00, 8'h00);
    chk("R10 pointer low half", {opValid, startCol}, {1'b1, 10'h022});
    @(negedge clk);
    wr(1, 0, 8'hFF);
    busyLen(n); chk("R10 reset while busy", n, 5);

    // R12 abort mid-sequence
    wr(1, 0, 8'h80); addr4(8'h00, 8'h41, 8'h00, 8'h00);
    wr(1, 0, 8'h90);
    chk("R12 no program", {opValid, busy}, 2'b00);
    wr(0, 1, 8'h00); rd(); chk("R12 fresh ID", ioOut, 8'hEC);
    wr(1, 0, 8'h10);
    chk("R12 stray confirm", {opValid, busy}, 2'b00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule